// File: doc/BRIEF.md
# Single-Queue Status Flag Generator with Prefetch Output Register

This block is one FIFO queue with its own status flags. Words enter through a write port and are held in core storage. When the read port is attached to the queue, the head word is moved ahead of time into a separate output register. A read therefore takes its word from that register, and the register is topped up again from the core. The queue reports four flags, all active low: output-valid, full, almost-full and almost-empty.

All four flags are derived from the number of words held in core storage. The output register is not counted. For that reason the write count at which each threshold is crossed is one higher while the read port is attached, because one word sits in the output register instead of the core. At reset an offset-select input picks the almost-full and almost-empty offsets, which are either both small or both large. A single clock drives the whole block.

Top module: `qflag_queue`

## Requirements
- R1: While reset is held and just after it is released, full_n, afull_n and ov_n are 1 and aempty_n is 0.
- R2: With rd_attach high, ov_n goes low after the second clock edge that follows the first write. The first edge stores the word and the second moves it into the output register. ov_n returns to 1 right after the edge of the read that takes the last word.
- R3: full_n goes to 0 right after the edge of the write that fills core storage. With the read port detached, that is the DEPTH-th write. With it attached, it is write DEPTH+1. A read that makes room returns full_n to 1 right after its edge.
- R4: afull_n is 0 whenever core storage holds at least DEPTH-m words. That is after DEPTH-m writes when detached and DEPTH+1-m writes when attached. The flag changes one clock edge later than the write edge, so it reacts on the second edge.
- R5: aempty_n is 1 whenever core storage holds more than n words. That is after n+1 writes when detached and n+2 writes when attached. The flag changes one clock edge later than the write edge.
- R6: dflt_hi is sampled on every clock edge while rst_n is low. A value of 0 selects m = n = OFS_LO (8) and a value of 1 selects m = n = OFS_HI (128). The selection holds until the next reset.
- R7: A write presented while full_n is 0 is ignored. It changes neither the stored contents nor the word count, so the words read back later are exactly the ones accepted.
- R8: A read presented while ov_n is 1, or while rd_attach is low, is ignored. The next word written is the next word read.
- R9: With rd_attach high, a word in core storage is moved into an empty output register on the next edge. The word in the output register is replaced from core storage on the same edge that consumes it. Words leave in write order. While detached, nothing is moved into the output register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Master reset, active low |
| dflt_hi | input | 1 | Offset select, sampled during reset (0: small, 1: large) |
| rd_attach | input | 1 | Read port is attached to this queue |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Write word |
| rd_en | input | 1 | Read request, consumes the output register |
| rd_data | output | WIDTH | Output register contents |
| ov_n | output | 1 | Output valid, active low |
| full_n | output | 1 | Core storage full, active low |
| afull_n | output | 1 | Almost full, active low |
| aempty_n | output | 1 | Almost empty, active low (0 = almost empty) |

## Verification
The hardest situation to reach is a full queue that is attached, with the output register occupied: a write arrives, is discarded, and the discard must be shown to have left no trace. The stimulus fills the attached queue with DEPTH+1 writes and offers one more word. It then drains every word and checks that the sequence ends on write DEPTH+1 with ov_n rising exactly there. The one-edge flag lag is checked by sampling just after each threshold-crossing write and again one edge later, once at each offset setting.

// File: rtl/qflag_pkg.sv
package qflag_pkg;

   // Offset chosen by the reset-time select input.
   function automatic int unsigned pick_ofs(input logic hi_sel,
                                            input int unsigned lo_val,
                                            input int unsigned hi_val);
      return hi_sel ? hi_val : lo_val;
   endfunction

endpackage

// File: rtl/qf_core_store.sv
module qf_core_store #(
   parameter int unsigned WIDTH = 16,
   parameter int unsigned DEPTH = 512
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           push,
   input  logic [WIDTH-1:0]               wdata,
   input  logic                           pop,
   output logic [WIDTH-1:0]               head,
   output logic [$clog2(DEPTH+1)-1:0]     count
);
   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW = $clog2(DEPTH+1);
   localparam bit          POW2 = ((1 << AW) == DEPTH);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr;
   logic [AW-1:0]    wr_ptr_nx, rd_ptr_nx;

   generate
      if (POW2) begin : g_wrap_free
         assign wr_ptr_nx = wr_ptr + AW'(1);
         assign rd_ptr_nx = rd_ptr + AW'(1);
      end else begin : g_wrap_cmp
         assign wr_ptr_nx = (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + AW'(1);
         assign rd_ptr_nx = (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + AW'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= wdata;
   end

   assign head = mem[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr_nx;
         if (pop)  rd_ptr <= rd_ptr_nx;
         case ({push, pop})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop) |-> (count < CW'(DEPTH))); // R7
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (count != '0)); // R8
   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((count == $past(count)) || (count == $past(count) + CW'(1))
                || (count + CW'(1) == $past(count)))); // R9

endmodule

// File: rtl/qf_out_stage.sv
module qf_out_stage #(
   parameter int unsigned WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             attach,
   input  logic             rd_en,
   input  logic             avail,
   input  logic [WIDTH-1:0] head,
   output logic             pop,
   output logic             valid,
   output logic [WIDTH-1:0] data
);
   logic take;
   logic load;

   assign take = rd_en && attach && valid;
   assign load = attach && avail && (!valid || take);
   assign pop  = load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    valid <= 1'b0;
      else if (load) valid <= 1'b1;
      else if (take) valid <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (load) data <= head;
   end

   AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !(rd_en && attach)) |=> (valid && $stable(data))); // R9
   AST_PREFETCH: assert property (@(posedge clk) disable iff (!rst_n)
      (attach && !valid && avail) |=> valid); // R9
   AST_NO_PREFETCH_DETACHED: assert property (@(posedge clk) disable iff (!rst_n)
      (!attach && !valid) |=> !valid); // R9
   AST_EMPTY_READ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid && !avail) |=> !valid); // R8

endmodule

// File: rtl/qf_flag_gen.sv
module qf_flag_gen
   import qflag_pkg::*;
#(
   parameter int unsigned DEPTH    = 512,
   parameter int unsigned OFS_LO   = 8,
   parameter int unsigned OFS_HI   = 128,
   parameter int unsigned FLAG_LAG = 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       ofs_hi,
   input  logic [$clog2(DEPTH+1)-1:0] count,
   output logic                       full_n,
   output logic                       afull_n,
   output logic                       aempty_n
);
   localparam int unsigned CW = $clog2(DEPTH+1);

   generate
      if (DEPTH <= 2*OFS_HI) begin : g_bad_depth
         $error("DEPTH must exceed twice the large offset");
      end
      if (OFS_LO == 0 || OFS_LO < FLAG_LAG) begin : g_bad_lo
         $error("small offset must be nonzero and at least FLAG_LAG");
      end
      if (OFS_LO > OFS_HI) begin : g_bad_order
         $error("small offset must not exceed large offset");
      end
   endgenerate

   logic [CW-1:0] ofs;
   logic [CW-1:0] af_thr;
   logic          af_raw, ae_raw;
   logic          af_q, ae_q;

   assign ofs    = CW'(pick_ofs(ofs_hi, OFS_LO, OFS_HI));
   assign af_thr = CW'(DEPTH) - ofs;
   assign af_raw = (count >= af_thr);
   assign ae_raw = (count <= ofs);
   assign full_n = (count != CW'(DEPTH));

   generate
      if (FLAG_LAG == 0) begin : g_direct
         assign af_q = af_raw;
         assign ae_q = ae_raw;
      end else begin : g_piped
         logic [FLAG_LAG-1:0] af_sr, ae_sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               af_sr <= '0;
               ae_sr <= '1;
            end else begin
               af_sr[0] <= af_raw;
               ae_sr[0] <= ae_raw;
               for (int i = 1; i < FLAG_LAG; i++) begin
                  af_sr[i] <= af_sr[i-1];
                  ae_sr[i] <= ae_sr[i-1];
               end
            end
         end
         assign af_q = af_sr[FLAG_LAG-1];
         assign ae_q = ae_sr[FLAG_LAG-1];
      end
   endgenerate

   assign afull_n  = !af_q;
   assign aempty_n = !ae_q;

   AST_AF_AE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(!afull_n && !aempty_n)); // R4
   AST_FULL_IMPLIES_AF: assert property (@(posedge clk) disable iff (!rst_n)
      !full_n |-> !afull_n); // R4

endmodule

// File: rtl/qflag_queue.sv
module qflag_queue #(
   parameter int unsigned WIDTH    = 16,
   parameter int unsigned DEPTH    = 512,
   parameter int unsigned OFS_LO   = 8,
   parameter int unsigned OFS_HI   = 128,
   parameter int unsigned FLAG_LAG = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dflt_hi,
   input  logic             rd_attach,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             rd_en,
   output logic [WIDTH-1:0] rd_data,
   output logic             ov_n,
   output logic             full_n,
   output logic             afull_n,
   output logic             aempty_n
);
   localparam int unsigned CW = $clog2(DEPTH+1);

   generate
      if (WIDTH == 0) begin : g_bad_width
         $error("WIDTH must be nonzero");
      end
   endgenerate

   logic             ofs_hi_q;
   logic             push, pop, ov_valid;
   logic [WIDTH-1:0] head;
   logic [CW-1:0]    count;

   always_ff @(posedge clk) begin
      if (!rst_n) ofs_hi_q <= dflt_hi;
   end

   assign push = wr_en && full_n;
   assign ov_n = !ov_valid;

   qf_core_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_core (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .wdata (wr_data),
      .pop   (pop),
      .head  (head),
      .count (count)
   );

   qf_out_stage #(.WIDTH(WIDTH)) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .attach (rd_attach),
      .rd_en  (rd_en),
      .avail  (count != '0),
      .head   (head),
      .pop    (pop),
      .valid  (ov_valid),
      .data   (rd_data)
   );

   qf_flag_gen #(.DEPTH(DEPTH), .OFS_LO(OFS_LO), .OFS_HI(OFS_HI),
                 .FLAG_LAG(FLAG_LAG)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .ofs_hi   (ofs_hi_q),
      .count    (count),
      .full_n   (full_n),
      .afull_n  (afull_n),
      .aempty_n (aempty_n)
   );

   AST_WRITE_FULL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !full_n && !pop) |=> (count == $past(count))); // R7
   AST_OFS_STATIC: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(ofs_hi_q)); // R6
   AST_FULL_DROPS_OV_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
      (!full_n && rd_attach) |=> !ov_n); // R2

endmodule

// File: tb/test_qflag_queue.sv
module test_qflag_queue;
   localparam int D  = 512;
   localparam int LO = 8;
   localparam int HI = 128;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dflt_hi = 1'b0;
   logic        rd_attach = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [15:0] rd_data;
   logic        ov_n, full_n, afull_n, aempty_n;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   qflag_queue i_qflag_queue (
      .clk(clk), .rst_n(rst_n), .dflt_hi(dflt_hi), .rd_attach(rd_attach),
      .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
      .ov_n(ov_n), .full_n(full_n), .afull_n(afull_n), .aempty_n(aempty_n)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic idle();
      @(negedge clk);
   endtask

   task automatic do_reset(input logic sel, input logic att);
      @(negedge clk);
      rst_n = 1'b0; dflt_hi = sel; rd_attach = att; wr_en = 0; rd_en = 0;
      repeat (3) @(negedge clk);
      chk("R1 full_n in reset", full_n, 1);
      chk("R1 aempty_n in reset", aempty_n, 0);
      rst_n = 1'b1; dflt_hi = ~sel;
      @(negedge clk);
   endtask

   task automatic wr(input int v);
      wr_en = 1'b1; wr_data = 16'(v);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd();
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic t_reset();
      do_reset(1'b0, 1'b0);
      chk("R1 full_n", full_n, 1);
      chk("R1 afull_n", afull_n, 1);
      chk("R1 ov_n", ov_n, 1);
      chk("R1 aempty_n", aempty_n, 0);
   endtask

   // Detached fill with small offsets, then attach and drain.
   task automatic t_detached_small();
      do_reset(1'b0, 1'b0);
      for (int k = 1; k <= D; k++) begin
         wr(k);
         chk("R3 full_n detached", full_n, (k == D) ? 0 : 1);
         if (k == D - LO) chk("R4 afull_n lag", afull_n, 1);
         if (k == LO + 1) chk("R5 aempty_n lag", aempty_n, 0);
         idle();
         chk("R4 afull_n detached R6 small", afull_n, (k >= D - LO) ? 0 : 1);
         chk("R5 aempty_n detached R6 small", aempty_n, (k > LO) ? 1 : 0);
         chk("R9 no prefetch detached", ov_n, 1);
      end
      wr(16'hBAD);
      chk("R7 full_n stays", full_n, 0);
      rd();
      chk("R8 read while detached", ov_n, 1);
      rd_attach = 1'b1;
      idle();
      chk("R9 prefetch ov_n", ov_n, 0);
      chk("R9 prefetch data", rd_data, 1);
      for (int i = 1; i <= D; i++) begin
         chk("R9 order", rd_data, i);
         rd();
      end
      chk("R2 ov_n after last read R7", ov_n, 1);
      rd();
      chk("R8 ov_n after empty read", ov_n, 1);
      wr(16'h55);
      idle();
      chk("R8 next write is next read", rd_data, 16'h55);
      chk("R2 ov_n valid", ov_n, 0);
   endtask

   // Attached fill with large offsets.
   task automatic t_attached_large();
      do_reset(1'b1, 1'b1);
      for (int k = 1; k <= D + 1; k++) begin
         wr(k);
         if (k == 1) chk("R2 ov_n one edge after write", ov_n, 1);
         chk("R3 full_n attached", full_n, (k == D + 1) ? 0 : 1);
         if (k == D + 1 - HI) chk("R4 afull_n lag attached", afull_n, 1);
         if (k == HI + 2) chk("R5 aempty_n lag attached", aempty_n, 0);
         idle();
         chk("R2 ov_n attached", ov_n, 0);
         chk("R4 afull_n attached R6 large", afull_n, (k >= D + 1 - HI) ? 0 : 1);
         chk("R5 aempty_n attached R6 large", aempty_n, (k >= HI + 2) ? 1 : 0);
      end
      wr(16'hBAD);
      idle();
      chk("R7 full_n after ignored write", full_n, 0);
      chk("R9 head word", rd_data, 1);
      rd();
      chk("R9 same-edge refill", rd_data, 2);
      chk("R3 full_n after read", full_n, 1);
      for (int i = 2; i <= D + 1; i++) begin
         chk("R7 R9 drain order", rd_data, i);
         rd();
      end
      chk("R7 R2 ov_n after final word", ov_n, 1);
   endtask

   initial begin
      t_reset();
      t_detached_small();
      t_attached_large();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #500000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule